// File: doc/BRIEF.md
# Oscillator Failure Detector

This block watches the main clock from a separate, always-running reference clock. It raises a reset request when the main clock runs too slowly or stops, and holds that request until the main clock comes back up to speed. A divided copy of the main clock crosses into the reference domain. All decisions are made in the reference domain, so the request can be entered and held while the main clock is dead.

The detector counts transitions of the divided signal over a fixed measurement window of reference cycles. A window with too few transitions counts as a failure. The first window after the detector becomes active is thrown away, because it may start partway through a clock restart. Software controls an enable bit and a sticky failure flag. The enable bit is also cleared by a power-fail reset. The flag is cleared only by software or by power-on reset. A stop-mode input tells the detector that the main clock has been halted on purpose. While it is high, no failure is reported.

Top module: `osc_fail_detect`

## Requirements
- R1: While and after `por_rst` is high, `det_en`, `fail_req` and `fail_flag` read 0.
- R2: A cycle with `sw_en_wr` high loads `sw_en_val` into `det_en`, visible after the next `ref_clk` edge.
- R3: With `det_en` 1 and `stop_mode` 0, a window of `WIN_CYC` reference cycles holding fewer than `MIN_EDGES` transitions of the synchronized divided clock raises `fail_req` one cycle after that window ends. Each transition stands for 2^`DIV_LOG2` main clock rising edges.
- R4: Once raised, `fail_req` stays 1 through every further failing window. It falls only at the end of a complete window with at least `MIN_EDGES` transitions.
- R5: The first window after `det_en` rises, or after `stop_mode` falls, is never evaluated. A dead main clock therefore raises `fail_req` only at the end of the second window.
- R6: A cycle with `stop_mode` high drives `fail_req` to 0 on the next edge. No window is evaluated while `stop_mode` stays high, so the flag cannot be set.
- R7: When `det_en` is 0, `fail_req` is 0 from the next edge on.
- R8: `fail_flag` becomes 1 in the same cycle that `fail_req` rises. It stays 1 after `fail_req` falls again.
- R9: `fail_flag` is cleared only by a `sw_flag_clr` pulse or by `por_rst`.
- R10: `pf_rst` clears `det_en` and wins over a simultaneous enable write. It leaves `fail_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Always-running reference clock; all decision logic |
| main_clk | input | 1 | Main clock under supervision |
| por_rst | input | 1 | Power-on reset, active high, asynchronous |
| pf_rst | input | 1 | Power-fail reset pulse, reference domain; clears enable |
| sw_en_wr | input | 1 | Enable write strobe |
| sw_en_val | input | 1 | Value written to the enable bit |
| sw_flag_clr | input | 1 | Clears the failure flag |
| stop_mode | input | 1 | Main clock deliberately stopped; suppresses detection |
| det_en | output | 1 | Current enable bit |
| fail_req | output | 1 | Reset request caused by a slow or dead main clock |
| fail_flag | output | 1 | Sticky record that a failure reset was requested |

## Verification
The hardest situation to reach is the discarded first window. The bench has to tell "a failure at the end of window one" apart from "a failure at the end of window two". It does this by holding the main clock dead and then releasing the enable bit, or the stop mode, at a known cycle. It samples `fail_req` one and a half windows later, when it must still be low, and again two and a half windows later, when it must be high. Recovery is reached by restarting the main clock while the request is held, then waiting out the partial window.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

   // per-window verdict handed from the window counter to the control logic
   typedef struct packed {
      logic done;    // last cycle of a window
      logic ok;      // transition tally reached the minimum
      logic first;   // window started right after activation, to be discarded
   } ofd_win_t;

endpackage

// File: rtl/ofd_prescale.sv
// Main clock domain: divides main_clk so the crossing signal toggles slowly.
module ofd_prescale #(
   parameter int DIV_LOG2 = 0
) (
   input  logic main_clk,
   input  logic rst,
   output logic tap
);
   generate
      if (DIV_LOG2 == 0) begin : g_toggle
         logic tgl;
         always_ff @(posedge main_clk or posedge rst) begin
            if (rst) tgl <= 1'b0;
            else     tgl <= ~tgl;
         end
         assign tap = tgl;
      end else begin : g_counter
         logic [DIV_LOG2:0] cnt;
         always_ff @(posedge main_clk or posedge rst) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + 1'b1;
         end
         assign tap = cnt[DIV_LOG2];
      end
   endgenerate
endmodule

// File: rtl/ofd_sync.sv
// Multi-flop synchronizer into the reference domain, followed by a transition detector.
module ofd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic edge_p
);
   logic [STAGES-1:0] pipe;
   logic              last;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or posedge rst) begin
               if (rst) pipe[0] <= 1'b0;
               else     pipe[0] <= din;
            end
         end else begin : g_tail
            always_ff @(posedge clk or posedge rst) begin
               if (rst) pipe[i] <= 1'b0;
               else     pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) last <= 1'b0;
      else     last <= pipe[STAGES-1];
   end

   assign edge_p = pipe[STAGES-1] ^ last;
endmodule

// File: rtl/ofd_window.sv
// Measurement window: counts transitions over WIN_CYC reference cycles.
module ofd_window
   import ofd_pkg::*;
#(
   parameter int WIN_CYC   = 64,
   parameter int MIN_EDGES = 8
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     active,
   input  logic     edge_p,
   output ofd_win_t verdict
);
   localparam int CNT_W  = $clog2(WIN_CYC);
   localparam int EDGE_W = $clog2(MIN_EDGES + 1);
   localparam logic [CNT_W-1:0]  LAST_V = CNT_W'(WIN_CYC - 1);
   localparam logic [EDGE_W-1:0] MIN_V  = EDGE_W'(MIN_EDGES);

   logic [CNT_W-1:0]  cyc;
   logic [EDGE_W-1:0] tally;
   logic [EDGE_W-1:0] tally_nx;
   logic              prime;
   logic              last_cyc;

   // saturating tally including a transition seen in the current cycle
   assign tally_nx = (tally == MIN_V) ? tally : tally + EDGE_W'(edge_p);
   assign last_cyc = (cyc == LAST_V);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cyc   <= '0;
         tally <= '0;
         prime <= 1'b1;
      end else if (!active) begin
         cyc   <= '0;
         tally <= '0;
         prime <= 1'b1;
      end else if (last_cyc) begin
         cyc   <= '0;
         tally <= '0;
         prime <= 1'b0;
      end else begin
         cyc   <= cyc + 1'b1;
         tally <= tally_nx;
      end
   end

   assign verdict.done  = active && last_cyc;
   assign verdict.ok    = (tally_nx >= MIN_V);
   assign verdict.first = prime;
endmodule

// File: rtl/ofd_ctrl.sv
// Enable bit, reset request and sticky flag, all in the reference domain.
module ofd_ctrl
   import ofd_pkg::*;
(
   input  logic     clk,
   input  logic     por_rst,
   input  logic     pf_rst,
   input  logic     sw_en_wr,
   input  logic     sw_en_val,
   input  logic     sw_flag_clr,
   input  logic     stop_mode,
   input  ofd_win_t verdict,
   output logic     active,
   output logic     en_q,
   output logic     req_q,
   output logic     flag_q
);
   logic judged;
   logic bad_win;

   assign active  = en_q && !stop_mode;
   assign judged  = verdict.done && !verdict.first;
   assign bad_win = active && judged && !verdict.ok;

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)       en_q <= 1'b0;
      else if (pf_rst)   en_q <= 1'b0;
      else if (sw_en_wr) en_q <= sw_en_val;
   end

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)     req_q <= 1'b0;
      else if (!active) req_q <= 1'b0;
      else if (judged) req_q <= !verdict.ok;
   end

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst)          flag_q <= 1'b0;
      else if (bad_win)     flag_q <= 1'b1;
      else if (sw_flag_clr) flag_q <= 1'b0;
   end
endmodule

// File: rtl/osc_fail_detect.sv
module osc_fail_detect
   import ofd_pkg::*;
#(
   parameter int WIN_CYC     = 64,
   parameter int MIN_EDGES   = 8,
   parameter int DIV_LOG2    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic main_clk,
   input  logic por_rst,
   input  logic pf_rst,
   input  logic sw_en_wr,
   input  logic sw_en_val,
   input  logic sw_flag_clr,
   input  logic stop_mode,
   output logic det_en,
   output logic fail_req,
   output logic fail_flag
);
   // elaboration-time parameter checks
   if (WIN_CYC < 4) begin : g_bad_win
      $error("WIN_CYC must be at least 4");
   end
   if (MIN_EDGES < 1 || MIN_EDGES > WIN_CYC / 2) begin : g_bad_min
      $error("MIN_EDGES must lie in 1..WIN_CYC/2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_LOG2 < 0 || DIV_LOG2 > 16) begin : g_bad_div
      $error("DIV_LOG2 must lie in 0..16");
   end

   logic     tap;
   logic     edge_p;
   logic     active;
   logic     win_done;
   ofd_win_t verdict;

   ofd_prescale #(.DIV_LOG2(DIV_LOG2)) u_prescale (
      .main_clk (main_clk),
      .rst      (por_rst),
      .tap      (tap)
   );

   ofd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (ref_clk),
      .rst    (por_rst),
      .din    (tap),
      .edge_p (edge_p)
   );

   ofd_window #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_window (
      .clk     (ref_clk),
      .rst     (por_rst),
      .active  (active),
      .edge_p  (edge_p),
      .verdict (verdict)
   );

   ofd_ctrl u_ctrl (
      .clk         (ref_clk),
      .por_rst     (por_rst),
      .pf_rst      (pf_rst),
      .sw_en_wr    (sw_en_wr),
      .sw_en_val   (sw_en_val),
      .sw_flag_clr (sw_flag_clr),
      .stop_mode   (stop_mode),
      .verdict     (verdict),
      .active      (active),
      .en_q        (det_en),
      .req_q       (fail_req),
      .flag_q      (fail_flag)
   );

   assign win_done = verdict.done;
endmodule

// File: rtl/ofd_chk.sv
module ofd_chk (
   input logic ref_clk,
   input logic por_rst,
   input logic pf_rst,
   input logic sw_flag_clr,
   input logic stop_mode,
   input logic det_en,
   input logic fail_req,
   input logic fail_flag,
   input logic win_done
);
   // R3
   req_rise_at_window_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      $rose(fail_req) |-> $past(win_done));

   // R4
   req_fall_at_window_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      ($fell(fail_req) && $past(det_en) && !$past(stop_mode)) |-> $past(win_done));

   // R6
   stop_clears_req_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      stop_mode |=> !fail_req);

   // R7
   disabled_no_req_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      !det_en |=> !fail_req);

   // R8
   flag_with_req_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      $rose(fail_req) |-> fail_flag);

   // R9
   flag_sticky_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      (fail_flag && !sw_flag_clr) |=> fail_flag);

   // R10
   pf_clears_en_chk: assert property (@(posedge ref_clk) disable iff (por_rst)
      pf_rst |=> !det_en);
endmodule

bind osc_fail_detect ofd_chk u_ofd_chk (
   .ref_clk     (ref_clk),
   .por_rst     (por_rst),
   .pf_rst      (pf_rst),
   .sw_flag_clr (sw_flag_clr),
   .stop_mode   (stop_mode),
   .det_en      (det_en),
   .fail_req    (fail_req),
   .fail_flag   (fail_flag),
   .win_done    (win_done)
);

// File: tb/test_osc_fail_detect.sv
`timescale 1ns/1ps
module test_osc_fail_detect;
   localparam int WIN  = 64;
   localparam int NVEC = 6;
   // main clock half period in ns (0 = stopped) and expected request after settling
   localparam int VEC_HALF [NVEC] = '{12, 40, 20, 0, 16, 100};
   localparam bit VEC_FAIL [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   logic ref_clk = 1'b0;
   logic main_clk = 1'b0;
   logic por_rst = 1'b1;
   logic pf_rst = 1'b0;
   logic sw_en_wr = 1'b0;
   logic sw_en_val = 1'b0;
   logic sw_flag_clr = 1'b0;
   logic stop_mode = 1'b0;
   logic det_en, fail_req, fail_flag;

   int main_half = 12;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 ref_clk = ~ref_clk;

   always begin
      if (main_half == 0) #8;
      else begin
         #(main_half) main_clk = ~main_clk;
      end
   end

   osc_fail_detect i_osc_fail_detect (
      .ref_clk     (ref_clk),
      .main_clk    (main_clk),
      .por_rst     (por_rst),
      .pf_rst      (pf_rst),
      .sw_en_wr    (sw_en_wr),
      .sw_en_val   (sw_en_val),
      .sw_flag_clr (sw_flag_clr),
      .stop_mode   (stop_mode),
      .det_en      (det_en),
      .fail_req    (fail_req),
      .fail_flag   (fail_flag)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic write_en(input logic v);
      sw_en_wr = 1'b1; sw_en_val = v;
      tick(1);
      sw_en_wr = 1'b0;
   endtask

   task automatic clear_flag();
      sw_flag_clr = 1'b1;
      tick(1);
      sw_flag_clr = 1'b0;
   endtask

   initial begin
      tick(3);
      // R1: reset state
      check("R1 det_en", det_en, 1'b0);
      check("R1 fail_req", fail_req, 1'b0);
      check("R1 fail_flag", fail_flag, 1'b0);
      por_rst = 1'b0;
      tick(2);

      // R2: enable write
      write_en(1'b1);
      check("R2 enable set", det_en, 1'b1);

      // table walk, R3/R4 under several main clock rates
      tick(3 * WIN);
      for (int v = 0; v < NVEC; v++) begin
         main_half = VEC_HALF[v];
         tick(3 * WIN);
         check(VEC_FAIL[v] ? "R3 slow clock request" : "R4 healthy clock release",
               fail_req, VEC_FAIL[v]);
      end
      check("R8 flag after table", fail_flag, 1'b1);

      // R7: disabling drops a held request, flag stays
      write_en(1'b0);
      tick(1);
      check("R7 request off when disabled", fail_req, 1'b0);
      check("R8 flag sticky", fail_flag, 1'b1);

      // R9: software clear of the flag
      clear_flag();
      check("R9 flag cleared", fail_flag, 1'b0);

      // R5: dead clock, first window after enable discarded
      main_half = 0;
      write_en(1'b1);
      tick(WIN + WIN / 2);
      check("R5 first window discarded", fail_req, 1'b0);
      check("R5 no flag in first window", fail_flag, 1'b0);
      tick(WIN);
      check("R3 dead clock request", fail_req, 1'b1);
      check("R8 flag on request", fail_flag, 1'b1);

      // R4: held through further failing windows
      tick(4 * WIN);
      check("R4 request held", fail_req, 1'b1);

      // R6: stop mode clears request and suppresses detection
      clear_flag();
      stop_mode = 1'b1;
      tick(2);
      check("R6 stop clears request", fail_req, 1'b0);
      tick(4 * WIN);
      check("R6 stop no request", fail_req, 1'b0);
      check("R6 stop no flag", fail_flag, 1'b0);

      // R5: first window after stop exit discarded
      stop_mode = 1'b0;
      tick(WIN + WIN / 2);
      check("R5 first window after stop", fail_req, 1'b0);
      tick(WIN);
      check("R3 request after stop exit", fail_req, 1'b1);

      // R4: recovery after clock restart; flag stays
      main_half = 16;
      tick(3 * WIN);
      check("R4 recovery", fail_req, 1'b0);
      check("R8 flag survives recovery", fail_flag, 1'b1);

      // R10: power-fail clears enable, beats write, keeps flag
      pf_rst = 1'b1; sw_en_wr = 1'b1; sw_en_val = 1'b1;
      tick(1);
      pf_rst = 1'b0; sw_en_wr = 1'b0;
      check("R10 pf clears enable", det_en, 1'b0);
      check("R10 pf keeps flag", fail_flag, 1'b1);

      // R9: clear without flag-clear keeps flag; power-on clears it
      tick(WIN);
      check("R9 flag untouched", fail_flag, 1'b1);
      write_en(1'b1);
      por_rst = 1'b1;
      tick(1);
      check("R9 por clears flag", fail_flag, 1'b0);
      check("R1 por clears enable", det_en, 1'b0);
      por_rst = 1'b0;
      tick(2);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge ref_clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule